// File: doc/BRIEF.md
# Adaptive Receive Equalizer with Gain Control and Three-Tap Decision Feedback

This block turns a stream of digitized line samples into bit decisions, one sample per unit interval (UI). Each sample is first scaled by an adaptive gain. Three feedback terms are then subtracted from it, each formed from an earlier decision and its own coefficient. The sign of the result is the decision for the current bit.

In the top rate mode, a sign-sign least-mean-squares loop adjusts the gain and the three coefficients on every sample. The gain steers the equalized magnitude toward a fixed target level. Each coefficient moves to cancel the inter-symbol interference that its earlier bit leaves in the current sample. In any lower rate mode, adaptation stops and the gain and coefficients are held at fixed defaults. The current gain and coefficients are always visible on observation outputs, with each coefficient in sign-magnitude form.

Top module: `dfe_agc_eq`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears itself. After that edge `gain_obs` is 32, every coefficient reads sign 0 and magnitude 0, and `bit_out` is 0.
- R2: One cycle after a sample is presented, `bit_out` is 1 if the equalized value y is zero or positive, and 0 if it is negative. y is (sample × gain) arithmetically shifted right by 5, minus the sum over k of c_k × d_k. Coefficient k (k = 0, 1, 2) uses the decision d_k taken k+1 UIs earlier. A decision bit of 1 counts as +1 and a bit of 0 counts as -1. Decision history resets to 0.
- R3: With `rate_top` high, the gain changes at each sample. It goes up by 1 when |y| is below the target of 64, goes down by 1 when |y| is above 64, and holds when |y| equals 64.
- R4: The gain stays within 0 to 127 and never wraps around.
- R5: With `rate_top` high, let the error e be y minus 64 for a 1 decision, or y plus 64 for a 0 decision. When e is zero, coefficient k holds. Otherwise it moves by one step: up (toward +63) when e > 0 and d_k is 1, or when e < 0 and d_k is 0, and down in the other two cases.
- R6: Each coefficient magnitude saturates at 63 in either sign. A coefficient with magnitude 0 always reads sign 0.
- R7: A clock edge with `rate_top` low loads a gain of 32 and all-zero coefficients, and holds them for as long as `rate_top` stays low. Decisions still follow R2.
- R8: `gain_obs` is the 7-bit gain. For coefficient k, the sign is `tap_sign_obs[k]` (1 means negative) and the magnitude is `tap_mag_obs[6k+5:6k]`.
- R9: An ideal channel is one whose samples are exactly +64 or -64, starting from the defaults. On such a channel the gain stays at 32 and all coefficients stay at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one UI per cycle |
| rst | input | 1 | Synchronous active-high reset |
| rate_top | input | 1 | 1 = top rate mode (adaptation on), 0 = lower rate (defaults held) |
| sample_in | input | 8 | Signed two's-complement line sample |
| bit_out | output | 1 | Decision for the sample of the previous cycle |
| gain_obs | output | 7 | Current gain, 32 = unity |
| tap_sign_obs | output | 3 | Coefficient signs, bit k for coefficient k |
| tap_mag_obs | output | 18 | Coefficient magnitudes, 6 bits each, coefficient 0 in the low bits |

## Verification
Gain and coefficient errors appear on the observation outputs one cycle after the faulty update. A wrong gain or coefficient also changes y, so it reaches `bit_out` and the next updates within a cycle or two. An error in the decision history shows up two to three cycles later, once the wrong bit lines up with a nonzero coefficient or the update direction. The bench therefore compares every output on every cycle against an independent reference model. It runs long intersymbol-interference streams so that saturation and sign crossings are reached.

// File: rtl/dfe_eq_pkg.sv
package dfe_eq_pkg;

  // Per-coefficient step request issued by the adaptation logic
  typedef enum logic [1:0] {
    MOVE_HOLD = 2'd0,
    MOVE_UP   = 2'd1,
    MOVE_DOWN = 2'd2
  } move_e;

endpackage

// File: rtl/dfe_tap_cell.sv
module dfe_tap_cell
  import dfe_eq_pkg::*;
#(
  parameter int MAGW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adapt_en,
  input  move_e           move,
  output logic            neg_q,
  output logic [MAGW-1:0] mag_q
);

  localparam logic [MAGW-1:0] MAG_MAX = {MAGW{1'b1}};
  localparam logic [MAGW-1:0] MAG_ONE = MAGW'(1);

  always_ff @(posedge clk) begin
    if (rst || !adapt_en) begin
      neg_q <= 1'b0;
      mag_q <= '0;
    end else begin
      case (move)
        MOVE_UP: begin
          if (neg_q) begin
            mag_q <= mag_q - MAG_ONE;
            if (mag_q == MAG_ONE) neg_q <= 1'b0;
          end else if (mag_q != MAG_MAX) begin
            mag_q <= mag_q + MAG_ONE;
          end
        end
        MOVE_DOWN: begin
          if (!neg_q && mag_q == '0) begin
            neg_q <= 1'b1;
            mag_q <= MAG_ONE;
          end else if (!neg_q) begin
            mag_q <= mag_q - MAG_ONE;
          end else if (mag_q != MAG_MAX) begin
            mag_q <= mag_q + MAG_ONE;
          end
        end
        default: ;
      endcase
    end
  end

  // signed view of the coefficient, used only by the checks below
  logic signed [MAGW+1:0] val;
  assign val = neg_q ? -$signed({2'b00, mag_q}) : $signed({2'b00, mag_q});

  p_zero_positive_r6: assert property (@(posedge clk) disable iff (rst)
    (mag_q == '0) |-> !neg_q);

  p_tap_step_r5: assert property (@(posedge clk) disable iff (rst)
    adapt_en |=> (((val - $past(val)) <= 1) && ((val - $past(val)) >= -1)));

  p_tap_default_r7: assert property (@(posedge clk) disable iff (rst)
    !adapt_en |=> (mag_q == '0 && !neg_q));

endmodule

// File: rtl/dfe_gain_ctrl.sv
module dfe_gain_ctrl #(
  parameter int GW     = 7,
  parameter int EW     = 18,
  parameter int TARGET = 64,
  parameter int DEF    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adapt_en,
  input  logic [EW-1:0] eq_mag,
  output logic [GW-1:0] gain_q
);

  localparam logic [GW-1:0] GMAX  = {GW{1'b1}};
  localparam logic [GW-1:0] GDEF  = GW'(DEF);
  localparam logic [EW-1:0] LEVEL = EW'(TARGET);

  always_ff @(posedge clk) begin
    if (rst || !adapt_en) begin
      gain_q <= GDEF;
    end else if (eq_mag < LEVEL) begin
      if (gain_q != GMAX) gain_q <= gain_q + GW'(1);
    end else if (eq_mag > LEVEL) begin
      if (gain_q != '0) gain_q <= gain_q - GW'(1);
    end
  end

  p_gain_step_r3: assert property (@(posedge clk) disable iff (rst)
    adapt_en |=> (({1'b0, gain_q} + 1'b1 >= {1'b0, $past(gain_q)}) &&
                  ({1'b0, gain_q} <= {1'b0, $past(gain_q)} + 1'b1)));

  p_gain_top_r4: assert property (@(posedge clk) disable iff (rst)
    (adapt_en && gain_q == GMAX) |=> (gain_q != '0));

  p_gain_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (adapt_en && gain_q == '0) |=> (gain_q != GMAX));

  p_gain_default_r7: assert property (@(posedge clk) disable iff (rst)
    !adapt_en |=> (gain_q == GDEF));

endmodule

// File: rtl/dfe_fb_sum.sv
module dfe_fb_sum #(
  parameter int NTAP = 3,
  parameter int MAGW = 6,
  parameter int FW   = 10
) (
  input  logic [NTAP-1:0]           tap_neg,
  input  logic [NTAP*MAGW-1:0]      tap_mag,
  input  logic [NTAP-1:0]           hist,
  output logic signed [FW-1:0]      fb
);

  logic signed [FW-1:0] term [NTAP];

  for (genvar k = 0; k < NTAP; k++) begin : g_term
    logic signed [FW-1:0] m;
    assign m = $signed(FW'(tap_mag[k*MAGW +: MAGW]));
    // product c_k * d_k is negative when exactly one of (coef<0, decision=-1) holds
    assign term[k] = (tap_neg[k] ^ ~hist[k]) ? -m : m;
  end

  always_comb begin
    fb = '0;
    for (int k = 0; k < NTAP; k++) fb = fb + term[k];
  end

endmodule

// File: rtl/dfe_agc_eq.sv
module dfe_agc_eq
  import dfe_eq_pkg::*;
#(
  parameter int SW     = 8,
  parameter int GW     = 7,
  parameter int MAGW   = 6,
  parameter int NTAP   = 3,
  parameter int GSHIFT = 5,
  parameter int TARGET = 64
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rate_top,
  input  logic signed [SW-1:0]   sample_in,
  output logic                   bit_out,
  output logic [GW-1:0]          gain_obs,
  output logic [NTAP-1:0]        tap_sign_obs,
  output logic [NTAP*MAGW-1:0]   tap_mag_obs
);

  localparam int PW       = SW + GW + 1;
  localparam int EW       = PW + 2;
  localparam int FW       = MAGW + 2 + $clog2(NTAP);
  localparam int DEF_GAIN = 1 << GSHIFT;

  logic [NTAP-1:0]        hist_q;
  logic [GW-1:0]          gain_q;
  logic [NTAP-1:0]        tap_neg;
  logic [NTAP*MAGW-1:0]   tap_mag;
  logic signed [FW-1:0]   fb;

  logic signed [PW-1:0]   s_ext, g_ext, prod, scaled;
  logic signed [EW-1:0]   eq, tgt, err;
  logic [EW-1:0]          eq_mag;
  logic                   dec, err_pos, err_zero;

  // gain scaling, feedback subtraction, slicer
  assign s_ext  = PW'(sample_in);
  assign g_ext  = $signed(PW'({1'b0, gain_q}));
  assign prod   = s_ext * g_ext;
  assign scaled = prod >>> GSHIFT;
  assign eq     = EW'(scaled) - EW'(fb);
  assign eq_mag = eq[EW-1] ? EW'(-eq) : EW'(eq);
  assign dec    = ~eq[EW-1];

  // slicer error against the ideal level of the chosen symbol
  assign tgt      = dec ? EW'(TARGET) : -EW'(TARGET);
  assign err      = eq - tgt;
  assign err_pos  = !err[EW-1] && (err != '0);
  assign err_zero = (err == '0);

  dfe_fb_sum #(.NTAP(NTAP), .MAGW(MAGW), .FW(FW)) u_fb (
    .tap_neg (tap_neg),
    .tap_mag (tap_mag),
    .hist    (hist_q),
    .fb      (fb)
  );

  dfe_gain_ctrl #(.GW(GW), .EW(EW), .TARGET(TARGET), .DEF(DEF_GAIN)) u_gain (
    .clk      (clk),
    .rst      (rst),
    .adapt_en (rate_top),
    .eq_mag   (eq_mag),
    .gain_q   (gain_q)
  );

  for (genvar k = 0; k < NTAP; k++) begin : g_tap
    move_e mv;
    assign mv = err_zero               ? MOVE_HOLD :
                (err_pos == hist_q[k]) ? MOVE_UP   : MOVE_DOWN;

    dfe_tap_cell #(.MAGW(MAGW)) u_tap (
      .clk      (clk),
      .rst      (rst),
      .adapt_en (rate_top),
      .move     (mv),
      .neg_q    (tap_neg[k]),
      .mag_q    (tap_mag[k*MAGW +: MAGW])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '0;
    else     hist_q <= {hist_q[NTAP-2:0], dec};
  end

  assign bit_out      = hist_q[0];
  assign gain_obs     = gain_q;
  assign tap_sign_obs = tap_neg;
  assign tap_mag_obs  = tap_mag;

  p_hist_shift_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (hist_q[NTAP-1:1] == $past(hist_q[NTAP-2:0])));

  p_ideal_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rate_top && err_zero) |=> (tap_mag_obs == $past(tap_mag_obs)));

endmodule

// File: tb/test_dfe_agc_eq.sv
module test_dfe_agc_eq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rate_top = 1'b0;
  logic signed [7:0] sample_in = '0;
  logic        bit_out;
  logic [6:0]  gain_obs;
  logic [2:0]  tap_sign_obs;
  logic [17:0] tap_mag_obs;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference state
  int m_gain;
  int m_tap [3];
  bit m_hist [3];
  bit isi [3];

  always #10 clk = ~clk;

  dfe_agc_eq i_dfe_agc_eq (
    .clk(clk), .rst(rst), .rate_top(rate_top), .sample_in(sample_in),
    .bit_out(bit_out), .gain_obs(gain_obs),
    .tap_sign_obs(tap_sign_obs), .tap_mag_obs(tap_mag_obs)
  );

  always @(posedge clk) cycles++;

  initial begin
    wait (cycles > 100000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_gain = 32;
    for (int k = 0; k < 3; k++) begin m_tap[k] = 0; m_hist[k] = 0; end
  endtask

  task automatic model_step(int s, bit rate);
    int eq, e, fb;
    bit d;
    fb = 0;
    for (int k = 0; k < 3; k++) fb += m_tap[k] * (m_hist[k] ? 1 : -1);
    eq = ((s * m_gain) >>> 5) - fb;
    d  = (eq >= 0);
    e  = eq - (d ? 64 : -64);
    if (!rate) begin
      m_gain = 32;
      for (int k = 0; k < 3; k++) m_tap[k] = 0;
    end else begin
      int a;
      a = (eq < 0) ? -eq : eq;
      if (a < 64 && m_gain < 127) m_gain++;
      else if (a > 64 && m_gain > 0) m_gain--;
      for (int k = 0; k < 3; k++) begin
        if (e != 0) begin
          if ((e > 0) == m_hist[k]) begin if (m_tap[k] < 63) m_tap[k]++; end
          else begin if (m_tap[k] > -63) m_tap[k]--; end
        end
      end
    end
    m_hist[2] = m_hist[1]; m_hist[1] = m_hist[0]; m_hist[0] = d;
  endtask

  task automatic compare_all();
    chk("R2 bit_out", bit_out, m_hist[0]);
    chk("R3 R4 gain_obs", gain_obs, m_gain);
    for (int k = 0; k < 3; k++) begin
      int mag;
      mag = (m_tap[k] < 0) ? -m_tap[k] : m_tap[k];
      chk("R5 R8 tap sign", tap_sign_obs[k], (m_tap[k] < 0) ? 1 : 0);
      chk("R5 R6 R8 tap magnitude", tap_mag_obs[k*6 +: 6], mag);
    end
  endtask

  // one UI: drive at the falling edge, check after the rising edge
  task automatic step(int s, bit rate);
    sample_in = 8'(s);
    rate_top  = rate;
    model_step(s, rate);
    @(posedge clk); #2;
    compare_all();
    @(negedge clk);
  endtask

  function automatic int isi_sample(bit b);
    int v;
    isi[2] = isi[1]; isi[1] = isi[0]; isi[0] = b;
    v = (isi[0] ? 45 : -45) + (isi[1] ? 20 : -20) + (isi[2] ? -9 : 9);
    return v;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    model_reset();
    chk("R1 gain reset", gain_obs, 32);
    chk("R1 tap sign reset", tap_sign_obs, 0);
    chk("R1 tap magnitude reset", tap_mag_obs, 0);
    chk("R1 bit_out reset", bit_out, 0);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rate_top = 1'b1;
    sample_in = 8'sd100;
    do_reset();
  endtask

  task automatic t_ideal_channel();
    do_reset();
    for (int i = 0; i < 40; i++) step(($urandom_range(0, 1) != 0) ? 64 : -64, 1'b1);
    chk("R9 gain stays unity", gain_obs, 32);
    chk("R9 taps stay zero", tap_mag_obs, 0);
  endtask

  task automatic t_low_rate_hold();
    do_reset();
    for (int i = 0; i < 30; i++) begin
      int s;
      s = $urandom_range(0, 255) - 128;
      step(s, 1'b0);
      chk("R7 gain held", gain_obs, 32);
      chk("R7 taps held", tap_mag_obs, 0);
      chk("R2 R7 plain slicer", bit_out, (s >= 0) ? 1 : 0);
    end
  endtask

  task automatic t_isi_adapt();
    do_reset();
    for (int i = 0; i < 400; i++) step(isi_sample(1'($urandom_range(0, 1))), 1'b1);
  endtask

  task automatic t_rate_drop();
    for (int i = 0; i < 60; i++) step(isi_sample(1'($urandom_range(0, 1))), 1'b1);
    step(isi_sample(1'b1), 1'b0);
    chk("R7 gain reload after rate drop", gain_obs, 32);
    chk("R7 taps reload after rate drop", tap_mag_obs, 0);
    chk("R6 zero taps positive", tap_sign_obs, 0);
    for (int i = 0; i < 50; i++) step(isi_sample(1'($urandom_range(0, 1))), 1'b1);
  endtask

  task automatic t_extremes();
    do_reset();
    for (int i = 0; i < 150; i++) step(127, 1'b1);
    for (int i = 0; i < 150; i++) step(2, 1'b1);
    for (int i = 0; i < 150; i++) step(-128, 1'b1);
    for (int i = 0; i < 200; i++) step(($urandom_range(0, 1) != 0) ? 3 : -3, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_ideal_channel();
    t_low_rate_hold();
    t_isi_adapt();
    t_rate_drop();
    t_extremes();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule